// File: doc/BRIEF.md
# Bidirectional Byte Serial Port

This block is a byte-wide serial port with one data register and one shift register. It moves bits over a serial data line, clocked by a count line. A direction bit chooses between two modes.

In output mode the port drives both lines. A CPU write loads the data register, and that byte is shifted out most-significant bit first. The count line runs at a pace set by an external underflow strobe. A byte written while another is still shifting is queued. It follows the current byte without any gap on the count line, and a single buffer-empty strobe marks the end of the whole run.

In input mode both lines are inputs. The block passes them through a flip-flop synchronizer and samples the data line on each rising edge of the count line. When eight bits have arrived, the assembled byte moves into the data register and an interrupt strobe is raised.

Top module: `serial_port_shifter`

## Requirements
- R1: After reset the port is in input mode. `rd_data` is 0, `cnt_out` is 1, `cnt_oe` and `sp_oe` are 0, and `irq` is 0.
- R2: In output mode a single written byte produces exactly 8 falling edges on `cnt_out`. The bits appear on `sp_out` most-significant first. `sp_out` changes only together with a falling edge of `cnt_out`, and a receiver samples each bit at the following rising edge.
- R3: `irq` is a one-cycle strobe. In output mode it is raised only after the last rising edge of `cnt_out` of a run, when no byte is queued.
- R4: A byte written while another is shifting is queued. The two bytes together produce 16 falling edges in one run, carry both bytes in order, and are followed by exactly one `irq` strobe.
- R5: In input mode (`dir_out`=0), a write updates `rd_data` only. `cnt_oe` and `sp_oe` stay 0, `cnt_out` stays 1, and no `irq` follows.
- R6: In input mode, `cnt_in` and `sp_in` pass through `SYNC_STAGES` flip-flops. `sp_in` is sampled on each rising edge of `cnt_in`, most-significant bit first. After the eighth edge the byte is copied to `rd_data` and one `irq` strobe is raised.
- R7: `cnt_oe` and `sp_oe` are 1 exactly when the registered mode is output. They follow `dir_out` one clock later.
- R8: Changing `dir_out` aborts any transfer, resets the bit counter, drops any queued byte and returns `cnt_out` to 1. No `irq` results from the aborted transfer.
- R9: Each `tick` pulse during a transfer moves `cnt_out` by one half-period. With no transfer, `cnt_out` stays 1 and `sp_out` holds its last value.
- R10: A write in the same cycle as a switch to output mode is kept. The shift register loads it only after the mode is established, and the byte is sent in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dir_out | input | 1 | Direction bit: 1 output, 0 input |
| wr_en | input | 1 | CPU write strobe for the data register |
| wr_data | input | DATA_W | CPU write data |
| rd_data | output | DATA_W | Data register contents for CPU reads |
| tick | input | 1 | Underflow strobe, one count-line half-period each |
| cnt_in | input | 1 | Count line as seen at the pin |
| cnt_out | output | 1 | Count line driven value |
| cnt_oe | output | 1 | Count line output enable |
| sp_in | input | 1 | Serial data line as seen at the pin |
| sp_out | output | 1 | Serial data line driven value |
| sp_oe | output | 1 | Serial data line output enable |
| irq | output | 1 | One-cycle transfer-complete strobe |

## Verification
The bench builds the block with its defaults: an 8-bit byte and a two-stage synchronizer. With these values the 8-bit terminal count is reached in every transfer, and a second byte can be queued mid-byte to exercise the back-to-back chain. The receive path can be driven slowly enough that the two-stage synchronizer latency stays well inside each count-line phase. The strobe spacing is drawn at random, so the count-line half-periods vary while the edge count and bit order must not.

// File: rtl/sps_pkg.sv
package sps_pkg;
    typedef enum logic {
        SPS_IN  = 1'b0,
        SPS_OUT = 1'b1
    } sps_dir_e;
endpackage

// File: rtl/sps_sync.sv
module sps_sync #(
    parameter int               WIDTH   = 1,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[i] <= RST_VAL;
                else        stage_q[i] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[i] <= RST_VAL;
                else        stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/serial_port_shifter.sv
module serial_port_shifter
    import sps_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dir_out,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic              tick,
    input  logic              cnt_in,
    output logic              cnt_out,
    output logic              cnt_oe,
    input  logic              sp_in,
    output logic              sp_out,
    output logic              sp_oe,
    output logic              irq
);
    localparam int                CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(DATA_W - 1);

    typedef struct packed {
        sps_dir_e          mode;
        logic [DATA_W-1:0] dreg;
        logic              pend;
        logic              active;
        logic [DATA_W-1:0] shreg;
        logic [CNT_W-1:0]  bitcnt;
        logic              cnt;
        logic              sp;
        logic              irq;
        logic              cnt_prev;
    } state_t;

    state_t s_d, s_q;
    logic   cnt_sync, sp_sync, rx_rise;

    sps_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES),
        .RST_VAL(2'b10)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({cnt_in, sp_in}),
        .q    ({cnt_sync, sp_sync})
    );

    assign rx_rise = cnt_sync & ~s_q.cnt_prev;

    always_comb begin
        s_d          = s_q;
        s_d.irq      = 1'b0;
        s_d.cnt_prev = cnt_sync;
        if (wr_en) s_d.dreg = wr_data;

        if (sps_dir_e'(dir_out) != s_q.mode) begin
            // direction change: abort and restart cleanly
            s_d.mode   = sps_dir_e'(dir_out);
            s_d.pend   = wr_en & dir_out;
            s_d.active = 1'b0;
            s_d.bitcnt = '0;
            s_d.cnt    = 1'b1;
            s_d.shreg  = '0;
        end else if (s_q.mode == SPS_OUT) begin
            if (wr_en) s_d.pend = 1'b1;
            if (!s_q.active) begin
                if (s_q.pend) begin
                    s_d.active = 1'b1;
                    s_d.shreg  = s_q.dreg;
                    s_d.bitcnt = '0;
                    s_d.pend   = wr_en;
                end
            end else if (tick) begin
                if (s_q.cnt) begin
                    s_d.cnt   = 1'b0;
                    s_d.sp    = s_q.shreg[DATA_W-1];
                    s_d.shreg = s_q.shreg << 1;
                end else begin
                    s_d.cnt = 1'b1;
                    if (s_q.bitcnt == LAST) begin
                        s_d.bitcnt = '0;
                        if (s_q.pend) begin
                            s_d.shreg = s_q.dreg;
                            s_d.pend  = wr_en;
                        end else begin
                            s_d.active = 1'b0;
                            s_d.irq    = 1'b1;
                        end
                    end else begin
                        s_d.bitcnt = s_q.bitcnt + 1'b1;
                    end
                end
            end
        end else begin
            if (rx_rise) begin
                s_d.shreg = {s_q.shreg[DATA_W-2:0], sp_sync};
                if (s_q.bitcnt == LAST) begin
                    s_d.bitcnt = '0;
                    s_d.dreg   = {s_q.shreg[DATA_W-2:0], sp_sync};
                    s_d.irq    = 1'b1;
                end else begin
                    s_d.bitcnt = s_q.bitcnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.mode     <= SPS_IN;
            s_q.cnt      <= 1'b1;
            s_q.cnt_prev <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_data = s_q.dreg;
    assign cnt_out = s_q.cnt;
    assign sp_out  = s_q.sp;
    assign cnt_oe  = (s_q.mode == SPS_OUT);
    assign sp_oe   = (s_q.mode == SPS_OUT);
    assign irq     = s_q.irq;

    // R3
    irq_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R2
    sp_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_oe && $changed(sp_out)) |-> $fell(cnt_out));

    // R9
    fall_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cnt_out) |-> $past(tick));

    // R5
    input_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_oe && !dir_out) |=> ($stable(cnt_out) && $stable(sp_out) && !cnt_oe));

    // R8
    switch_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_out != cnt_oe) |=> (cnt_out && (cnt_oe == $past(dir_out))));

    // R7
    oe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_oe == sp_oe);
endmodule

// File: tb/serial_port_shifter_tb.sv
module serial_port_shifter_tb;
    localparam int DATA_W = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dir_out = 1'b0;
    logic              wr_en = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [DATA_W-1:0] rd_data;
    logic              tick = 1'b0;
    logic              cnt_in = 1'b1;
    logic              cnt_out, cnt_oe;
    logic              sp_in = 1'b0;
    logic              sp_out, sp_oe;
    logic              irq;

    int errors = 0;
    int checks = 0;
    int falls = 0;
    int irqs = 0;
    int cycles = 0;
    logic [15:0] cap = '0;
    logic        cnt_seen = 1'b1;
    int unsigned seed = 32'd1234;

    always #2.5 clk = ~clk;

    serial_port_shifter #(.DATA_W(DATA_W), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .tick(tick),
        .cnt_in(cnt_in), .cnt_out(cnt_out), .cnt_oe(cnt_oe),
        .sp_in(sp_in), .sp_out(sp_out), .sp_oe(sp_oe), .irq(irq)
    );

    // random-spaced underflow strobes
    initial begin
        void'($urandom(seed));
        forever begin
            repeat ($urandom_range(3, 1)) @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    end

    // line monitor
    always @(negedge clk) begin
        cycles <= cycles + 1;
        if (rst_n) begin
            if (cnt_oe && cnt_seen && !cnt_out) falls <= falls + 1;
            if (cnt_oe && !cnt_seen && cnt_out) cap <= {cap[14:0], sp_out};
            if (irq) irqs <= irqs + 1;
        end
        cnt_seen <= cnt_out;
    end

    function automatic int exp_falls(input int nbytes);
        return nbytes * DATA_W;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [DATA_W-1:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_irq(input int base, input int limit);
        for (int i = 0; i < limit && irqs == base; i++) @(negedge clk);
    endtask

    task automatic send(input logic [DATA_W-1:0] a, input bit two, input logic [DATA_W-1:0] b);
        int f0, i0;
        f0 = falls;
        i0 = irqs;
        cpu_write(a);
        if (two) begin
            for (int i = 0; i < 200 && falls < f0 + 2; i++) @(negedge clk);
            cpu_write(b);
        end
        wait_irq(i0, 600);
        repeat (20) @(negedge clk);
        if (two) begin
            // R4
            check("R4 pulses", falls - f0, exp_falls(2));
            check("R4 irq count", irqs - i0, 1);
            check("R4 data order", 32'(cap), 32'({a, b}));
        end else begin
            // R2
            check("R2 pulses", falls - f0, exp_falls(1));
            check("R2 msb-first data", 32'(cap[7:0]), 32'(a));
            // R3
            check("R3 irq count", irqs - i0, 1);
        end
        // R9
        check("R9 idle cnt high", 32'(cnt_out), 1);
    endtask

    task automatic recv(input logic [DATA_W-1:0] v);
        int i0;
        i0 = irqs;
        for (int k = DATA_W - 1; k >= 0; k--) begin
            cnt_in = 1'b0;
            repeat (3) @(negedge clk);
            sp_in = v[k];
            repeat (3) @(negedge clk);
            cnt_in = 1'b1;
            repeat (4) @(negedge clk);
        end
        repeat (6) @(negedge clk);
        // R6
        check("R6 rx byte", 32'(rd_data), 32'(v));
        check("R6 rx irq", irqs - i0, 1);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (cycles > 150000) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        int f0, i0;
        logic [DATA_W-1:0] v;
        repeat (3) @(negedge clk);
        // R1
        check("R1 rd_data", 32'(rd_data), 0);
        check("R1 cnt_out", 32'(cnt_out), 1);
        check("R1 oe", 32'({cnt_oe, sp_oe}), 0);
        check("R1 irq", 32'(irq), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R5: write in input mode
        f0 = falls; i0 = irqs;
        cpu_write(8'hA5);
        repeat (40) @(negedge clk);
        check("R5 rd_data", 32'(rd_data), 32'h A5);
        check("R5 no drive", 32'({cnt_oe, sp_oe, cnt_out}), 32'b001);
        check("R5 no irq", irqs - i0, 0);

        // R6 receive
        recv(8'h3C);
        recv(8'h81);
        for (int n = 0; n < 4; n++) recv(8'($urandom()));

        // R7 mode follows one clock later
        @(negedge clk);
        dir_out = 1'b1;
        check("R7 oe before", 32'(cnt_oe), 0);
        @(negedge clk);
        check("R7 oe after", 32'({cnt_oe, sp_oe}), 32'b11);
        repeat (3) @(negedge clk);

        send(8'h80, 1'b0, 8'h00);
        send(8'h01, 1'b0, 8'h00);
        send(8'hC3, 1'b1, 8'h5A);
        for (int n = 0; n < 5; n++) begin
            v = 8'($urandom());
            if (n[0]) send(v, 1'b1, 8'($urandom()));
            else      send(v, 1'b0, 8'h00);
        end

        // R8 abort mid-byte with a queued byte
        f0 = falls; i0 = irqs;
        cpu_write(8'hF0);
        for (int i = 0; i < 200 && falls < f0 + 3; i++) @(negedge clk);
        cpu_write(8'h0F);
        dir_out = 1'b0;
        repeat (60) @(negedge clk);
        check("R8 no irq after abort", irqs - i0, 0);
        check("R8 cnt released high", 32'(cnt_out), 1);
        f0 = falls;
        dir_out = 1'b1;
        repeat (120) @(negedge clk);
        check("R8 queue dropped", falls - f0, 0);
        check("R8 still no irq", irqs - i0, 0);

        // R10 write coinciding with switch to output
        dir_out = 1'b0;
        repeat (5) @(negedge clk);
        f0 = falls; i0 = irqs;
        dir_out = 1'b1;
        wr_en = 1'b1;
        wr_data = 8'h96;
        @(negedge clk);
        wr_en = 1'b0;
        wait_irq(i0, 600);
        repeat (20) @(negedge clk);
        check("R10 pulses", falls - f0, exp_falls(1));
        check("R10 data", 32'(cap[7:0]), 32'h96);
        check("R10 irq", irqs - i0, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule